// File: doc/BRIEF.md
# Program-Busy Status Readback

This block forms the byte a byte-wide non-volatile memory returns on its data bus while the host polls it. A host starts a read by pulling chip-enable and output-enable low with write-enable high. When the array is idle, the block returns the array byte. While an internal programming cycle runs (`busy` high), it returns a status byte instead. The top bit is the inverse of the top bit last written if the host reads the address it last wrote. The next bit flips once per read transaction. The remaining low bits read as zero. A host can therefore poll either the written location or any location to learn when programming has finished.

The block also times the byte-load window of a page write. Each write strobe (chip-enable and write-enable low, output-enable high) reloads a countdown. The window stays open until the countdown runs out, and a one-cycle pulse marks that moment. Reads strobed between byte loads leave this countdown untouched.

A small bus state machine tracks the transaction type. Its states are `S_IDLE` (no transaction), `S_READ` (read strobe held) and `S_WRITE` (write strobe held). Its transitions are: idle-to-read and write-to-read when a read strobe appears; idle-to-write and read-to-write when a write strobe appears; read-to-idle and write-to-idle when the strobe goes away. A read starts on any cycle with a read strobe while the state is not `S_READ`.

Top module: `sts_poll_readback`

## Requirements
- R1: `dq_oe` is 1 exactly when `ce_n`=0, `oe_n`=0 and `we_n`=1 in the same cycle; in every other cycle the bus is released.
- R2: During a read with `busy`=0, `dq_out` equals `array_data`.
- R3: During a read with `busy`=1 and `rd_addr`=`last_addr`, bit DATA_W-1 of `dq_out` is the inverse of `last_wr_msb`.
- R4: During a read with `busy`=1 and `rd_addr`≠`last_addr`, bit DATA_W-1 of `dq_out` is 0.
- R5: During a read with `busy`=1, bits DATA_W-3 down to 0 of `dq_out` are 0.
- R6: With `busy`=1, bit DATA_W-2 of `dq_out` inverts at the first cycle of each new read transaction and holds for the rest of that transaction.
- R7: A read with `busy`=0 does not advance the toggle bit. A later busy read continues from the last value shown.
- R8: The cycle after a write strobe is sampled, `load_open` rises. It stays high for LOAD_WIN_CYC cycles after the last cycle of that strobe. In the next cycle `load_open` is 0 and `load_expire` is 1 for one cycle.
- R9: A new write strobe inside the window restarts the countdown from LOAD_WIN_CYC.
- R10: Read transactions neither restart, shorten nor open the byte-load window.
- R11: While `dq_oe` is 0, `dq_out` is all zeros.
- R12: After reset, `dq_oe`, `load_open` and `load_expire` are 0, and the toggle bit starts at 0, so the first busy read shows 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| busy | input | 1 | Internal programming cycle in progress |
| rd_addr | input | ADDR_W | Address presented on the read |
| last_addr | input | ADDR_W | Address of the last byte written |
| last_wr_msb | input | 1 | Top bit of the last byte written |
| array_data | input | DATA_W | Array read data for `rd_addr` |
| dq_out | output | DATA_W | Byte driven on the bus |
| dq_oe | output | 1 | Bus drive enable (0 = high impedance) |
| load_open | output | 1 | Byte-load window open |
| load_expire | output | 1 | One-cycle pulse when the window closes |

## Verification
The bench builds the block with DATA_W=8, ADDR_W=13 and LOAD_WIN_CYC=12. The short window lets the expiry pulse, a restart by a second strobe and reads interleaved inside the window all happen within a few dozen cycles. The 8-bit width puts the status bits at positions 7 and 6 with six reserved bits, so every status field is exercised. The reference model tracks the toggle bit across busy and idle reads and across runs of back-to-back reads.

// File: rtl/sts_pkg.sv
`timescale 1ns/1ps
package sts_pkg;
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_READ  = 2'd1,
        S_WRITE = 2'd2
    } bus_st_e;
endpackage

// File: rtl/sts_bus_fsm.sv
`timescale 1ns/1ps
module sts_bus_fsm
    import sts_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic oe_n,
    input  logic we_n,
    output logic rd_active,
    output logic rd_start,
    output logic wr_active
);
    bus_st_e st_q, st_d;
    logic    rd_req, wr_req;

    assign rd_req = !ce_n && !oe_n && we_n;
    assign wr_req = !ce_n && !we_n && oe_n;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= S_IDLE;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            S_IDLE: begin
                if (rd_req)      st_d = S_READ;
                else if (wr_req) st_d = S_WRITE;
            end
            S_READ: begin
                if (wr_req)      st_d = S_WRITE;
                else if (!rd_req) st_d = S_IDLE;
            end
            S_WRITE: begin
                if (rd_req)      st_d = S_READ;
                else if (!wr_req) st_d = S_IDLE;
            end
            default: st_d = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        rd_active = rd_req;
        wr_active = wr_req;
        rd_start  = rd_req && (st_q != S_READ);
    end
endmodule

// File: rtl/sts_toggle_reg.sv
`timescale 1ns/1ps
module sts_toggle_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_start,
    input  logic busy,
    output logic tog_shown
);
    logic tog_q;

    // flip is visible in the first cycle of the transaction
    assign tog_shown = tog_q ^ (rd_start && busy);

    always_ff @(posedge clk) begin
        if (!rst_n) tog_q <= 1'b0;
        else        tog_q <= tog_shown;
    end
endmodule

// File: rtl/sts_load_timer.sv
`timescale 1ns/1ps
module sts_load_timer #(
    parameter int LOAD_WIN_CYC = 20000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_active,
    output logic load_open,
    output logic load_expire
);
    localparam int CNT_W = $clog2(LOAD_WIN_CYC + 1);

    logic [CNT_W-1:0] cnt_q;
    logic             exp_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            exp_q <= 1'b0;
        end else begin
            exp_q <= (cnt_q == CNT_W'(1)) && !wr_active;
            if (wr_active)          cnt_q <= CNT_W'(LOAD_WIN_CYC);
            else if (cnt_q != '0)   cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign load_open   = (cnt_q != '0);
    assign load_expire = exp_q;
endmodule

// File: rtl/sts_read_mux.sv
`timescale 1ns/1ps
module sts_read_mux #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 13
) (
    input  logic              rd_active,
    input  logic              busy,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [ADDR_W-1:0] last_addr,
    input  logic              last_wr_msb,
    input  logic [DATA_W-1:0] array_data,
    input  logic              tog_shown,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe
);
    localparam int RSV_W = DATA_W - 2;

    logic [DATA_W-1:0] status_byte;
    logic              poll_bit;

    assign poll_bit    = (rd_addr == last_addr) ? ~last_wr_msb : 1'b0;
    assign status_byte = {poll_bit, tog_shown, {RSV_W{1'b0}}};

    always_comb begin
        dq_oe = rd_active;
        if (!rd_active) dq_out = '0;
        else if (busy)  dq_out = status_byte;
        else            dq_out = array_data;
    end
endmodule

// File: rtl/sts_poll_readback.sv
`timescale 1ns/1ps
module sts_poll_readback #(
    parameter int DATA_W       = 8,
    parameter int ADDR_W       = 13,
    parameter int LOAD_WIN_CYC = 20000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              busy,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [ADDR_W-1:0] last_addr,
    input  logic              last_wr_msb,
    input  logic [DATA_W-1:0] array_data,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe,
    output logic              load_open,
    output logic              load_expire
);
    logic rd_active, rd_start, wr_active, tog_shown;

    sts_bus_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ce_n      (ce_n),
        .oe_n      (oe_n),
        .we_n      (we_n),
        .rd_active (rd_active),
        .rd_start  (rd_start),
        .wr_active (wr_active)
    );

    sts_toggle_reg u_tog (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_start  (rd_start),
        .busy      (busy),
        .tog_shown (tog_shown)
    );

    sts_load_timer #(.LOAD_WIN_CYC(LOAD_WIN_CYC)) u_tmr (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_active   (wr_active),
        .load_open   (load_open),
        .load_expire (load_expire)
    );

    sts_read_mux #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mux (
        .rd_active   (rd_active),
        .busy        (busy),
        .rd_addr     (rd_addr),
        .last_addr   (last_addr),
        .last_wr_msb (last_wr_msb),
        .array_data  (array_data),
        .tog_shown   (tog_shown),
        .dq_out      (dq_out),
        .dq_oe       (dq_oe)
    );
endmodule

// File: rtl/sts_poll_checker.sv
`timescale 1ns/1ps
module sts_poll_checker #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ce_n,
    input logic              oe_n,
    input logic              we_n,
    input logic              busy,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [ADDR_W-1:0] last_addr,
    input logic              last_wr_msb,
    input logic [DATA_W-1:0] array_data,
    input logic [DATA_W-1:0] dq_out,
    input logic              dq_oe,
    input logic              load_open,
    input logic              load_expire
);
    p_hiz_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n || oe_n || !we_n) |-> !dq_oe);

    p_idle_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_oe && !busy) |-> (dq_out == array_data));

    p_poll_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_oe && busy && (rd_addr == last_addr)) |-> (dq_out[DATA_W-1] != last_wr_msb));

    p_other_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_oe && busy && (rd_addr != last_addr)) |-> !dq_out[DATA_W-1]);

    p_reserved_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_oe && busy) |-> (dq_out[DATA_W-3:0] == '0));

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_oe && busy && $past(dq_oe) && $past(busy) && $past(rst_n))
        |-> (dq_out[DATA_W-2] == $past(dq_out[DATA_W-2])));

    p_wr_opens_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !we_n && oe_n) |=> (load_open && !load_expire));

    p_expire_r8: assert property (@(posedge clk) disable iff (!rst_n)
        load_expire |-> (!load_open && $past(load_open)));

    p_no_open_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_open && !(!ce_n && !we_n && oe_n)) |=> !load_open);

    p_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !dq_oe |-> (dq_out == '0));
endmodule

bind sts_poll_readback sts_poll_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_sts_poll_readback.sv
`timescale 1ns/1ps
module sim_sts_poll_readback;
    localparam int DW  = 8;
    localparam int AW  = 13;
    localparam int WIN = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic          busy = 1'b0;
    logic [AW-1:0] rd_addr = '0, last_addr = '0;
    logic          last_wr_msb = 1'b0;
    logic [DW-1:0] array_data = '0;
    logic [DW-1:0] dq_out;
    logic          dq_oe, load_open, load_expire;

    int n_tests = 0, n_fail = 0;
    int open_cycles = 0;
    bit seen_expire = 0;
    bit done = 0;

    // reference model state
    int m_st = 0;   // 0 none, 1 reading, 2 writing
    int m_tog = 0;
    int m_cnt = 0;
    int m_exp = 0;

    always #2.5 clk = ~clk;

    sts_poll_readback #(.DATA_W(DW), .ADDR_W(AW), .LOAD_WIN_CYC(WIN)) u0 (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .busy(busy), .rd_addr(rd_addr), .last_addr(last_addr),
        .last_wr_msb(last_wr_msb), .array_data(array_data),
        .dq_out(dq_out), .dq_oe(dq_oe), .load_open(load_open),
        .load_expire(load_expire)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit is_rd();
        return !ce_n && !oe_n && we_n;
    endfunction
    function automatic bit is_wr();
        return !ce_n && !we_n && oe_n;
    endfunction

    // model update
    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_tog = 0; m_cnt = 0; m_exp = 0;
        end else begin
            if (is_rd() && m_st != 1 && busy) m_tog = 1 - m_tog;
            m_exp = (m_cnt == 1 && !is_wr()) ? 1 : 0;
            if (is_wr()) m_cnt = WIN;
            else if (m_cnt > 0) m_cnt = m_cnt - 1;
            m_st = is_rd() ? 1 : (is_wr() ? 2 : 0);
        end
    end

    // per-cycle comparison
    always @(negedge clk) begin
        if (rst_n && !done) begin
            int t;
            t = (is_rd() && m_st != 1 && busy) ? 1 - m_tog : m_tog;
            chk("R1 oe", int'(dq_oe), int'(is_rd()));
            if (!is_rd()) chk("R11 data", int'(dq_out), 0);
            else if (!busy) chk("R2 data", int'(dq_out), int'(array_data));
            else begin
                if (rd_addr == last_addr) chk("R3 bit7", int'(dq_out[7]), int'(!last_wr_msb));
                else                      chk("R4 bit7", int'(dq_out[7]), 0);
                chk("R6 bit6", int'(dq_out[6]), t);
                chk("R5 low", int'(dq_out[5:0]), 0);
            end
            chk("R8 open", int'(load_open), int'(m_cnt != 0));
            chk("R8 expire", int'(load_expire), m_exp);
            if (load_open) open_cycles++;
            if (load_expire) seen_expire = 1;
        end
    end

    task automatic bus(input bit c, input bit o, input bit w, input int a);
        @(posedge clk); #1;
        ce_n = c; oe_n = o; we_n = w; rd_addr = AW'(a);
    endtask

    task automatic rel();
        bus(1, 1, 1, 0);
    endtask

    task automatic rd_chk(input int a, input string tag, input int exp);
        bus(0, 0, 1, a);
        @(negedge clk);
        chk(tag, int'(dq_out), exp);
    endtask

    task automatic wait_expire();
        for (int i = 0; i < 100 && !seen_expire; i++) @(posedge clk);
    endtask

    initial begin
        #1000000;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R12 oe", int'(dq_oe), 0);
        chk("R12 open", int'(load_open), 0);
        chk("R12 expire", int'(load_expire), 0);

        // idle reads return array data
        array_data = 8'h5A;
        rd_chk(16, "R2 idle read", 8'h5A);
        rel();
        rd_chk(16, "R2 idle read again", 8'h5A);
        rel();

        // busy polling
        busy = 1; last_addr = 13'h123; last_wr_msb = 0;
        rd_chk(13'h123, "R12 first busy read", 8'hC0);
        @(posedge clk); #1; @(negedge clk);
        chk("R6 held in transaction", int'(dq_out), 8'hC0);
        rel(); @(negedge clk);
        chk("R1 released", int'(dq_oe), 0);
        chk("R11 zero when released", int'(dq_out), 0);
        rd_chk(13'h123, "R6 flip", 8'h80);
        rel();
        rd_chk(13'h007, "R4 other address", 8'h40);
        rel();
        last_wr_msb = 1;
        rd_chk(13'h123, "R3 msb one", 8'h00);
        rel();

        // not busy: toggling stops
        busy = 0; array_data = 8'hA7;
        rd_chk(13'h123, "R7 true data", 8'hA7);
        rel();
        rd_chk(13'h123, "R7 true data again", 8'hA7);
        rel();
        busy = 1;
        rd_chk(13'h007, "R7 toggle continues", 8'h40);
        rel();
        busy = 0;

        // read blocked by write enable
        bus(0, 0, 0, 0); @(negedge clk);
        chk("R1 we low", int'(dq_oe), 0);
        rel();
        wait_expire();

        // single write window
        repeat (3) @(posedge clk);
        open_cycles = 0; seen_expire = 0;
        bus(0, 1, 0, 0); rel();
        wait_expire();
        chk("R8 window length", open_cycles, WIN);

        // restart by a second strobe
        @(posedge clk);
        open_cycles = 0; seen_expire = 0;
        bus(0, 1, 0, 0); rel();
        repeat (4) @(posedge clk);
        bus(0, 1, 0, 0); rel();
        wait_expire();
        chk("R9 restarted window", open_cycles, WIN + 6);

        // reads inside the window
        @(posedge clk);
        open_cycles = 0; seen_expire = 0;
        bus(0, 1, 0, 0); rel();
        for (int k = 0; k < 4; k++) begin
            bus(0, 0, 1, k); rel();
        end
        wait_expire();
        chk("R10 reads leave window", open_cycles, WIN);
        for (int k = 0; k < 3; k++) begin
            bus(0, 0, 1, k); rel();
        end
        @(negedge clk);
        chk("R10 reads do not open", int'(load_open), 0);

        repeat (2) @(posedge clk);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule